// File: doc/BRIEF.md
# Folded 9/7 Lifting Wavelet Analyser

This block takes a block of signed integer samples and computes one level of the forward biorthogonal 9/7 wavelet transform by lifting. Samples arrive over a valid/ready input. The block stores them and then runs the four lifting updates in place. Each update is a predict on the odd positions or an update on the even positions. All four updates go through one shared add-multiply-round path, and the constant is switched for each pass. After the last pass, each stored value is scaled and rounded to an integer. The values are then presented in sample order, tagged low-pass (even position) or high-pass (odd position).

A block ends on the sample flagged as last, or when the buffer depth is reached. While the block is lifted and emitted the input stalls. Both block ends use whole-sample symmetric extension, so the block needs no padding.

Top module: `wl97_fold_dwt`

## Requirements
- R1: A sample is taken on a clock edge where `in_valid` and `in_ready` are both high. A block closes on the sample that carries `in_last`, or on the NMAX-th sample even if `in_last` is low. Blocks hold 2 to NMAX samples. After a block closes, `in_ready` is low from the next cycle.
- R2: `in_ready` stays low until the cycle in which the last coefficient of the block is presented. It returns high in that same cycle.
- R3: A block of N samples gives exactly N outputs, on consecutive cycles, in sample order. The tag `out_high` is 0 for even positions and 1 for odd positions, so the first output is always low-pass and the tags alternate. `out_valid` is low at all other times.
- R4: Lifting runs in four in-place passes, each applying x_i += c * (x_{i-1} + x_{i+1}):
  - c = -1.586134342 on odd positions;
  - then c = -0.052980118 on even positions;
  - then c = 0.8829110762 on odd positions;
  - then c = 0.4435068522 on even positions.
- R5: A missing neighbour is mirrored about the end sample without repeating it: position -1 reads position 1, and position N reads position N-2.
- R6: A low-pass output is the lifted even value times 1.149604398. A high-pass output is the lifted odd value divided by 1.149604398. Both are rounded to the nearest integer and lie within 1 of the exact real-valued result.
- R7: After reset, `in_ready` is high and `out_valid` is low.
- R8: For an odd block length the last output is a low-pass value, so there is one more low-pass than high-pass coefficient.
- R9: Cycles with `in_valid` low between samples of a block are skipped and do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Block can take a sample |
| in_data | input | DW | Signed input sample |
| in_last | input | 1 | Marks the final sample of a block |
| out_valid | output | 1 | Coefficient present |
| out_high | output | 1 | 1 = high-pass, 0 = low-pass |
| out_data | output | DW+4 | Signed rounded coefficient |

## Verification
The hardest situation to reach from the ports is a mirrored neighbour feeding a value that an earlier pass has already changed. At the far end of a block this differs between even and odd lengths. The stimulus places impulses at the first position and near the last. It runs odd lengths (7, 9, 31) next to even ones and the shortest length of two, where every neighbour is a mirror. It also fills the buffer without a last flag, so that the forced close and the far-end mirror happen together at the deepest position.

// File: rtl/wl97_pkg.sv
package wl97_pkg;

    typedef enum logic [1:0] {
        PH_LOAD = 2'd0,
        PH_LIFT = 2'd1,
        PH_EMIT = 2'd2
    } phase_e;

    localparam real LIFT_A = -1.586134342;
    localparam real LIFT_B = -0.052980118;
    localparam real LIFT_G = 0.8829110762;
    localparam real LIFT_D = 0.4435068522;
    localparam real NORM_K = 1.149604398;

    // real constant -> round-to-nearest fixed point with f fraction bits
    function automatic int qcoef(real v, int f);
        real s;
        s = v * (2.0 ** f);
        return (s >= 0.0) ? $rtoi(s + 0.5) : -$rtoi(0.5 - s);
    endfunction

endpackage

// File: rtl/wl97_shadd.sv
// Signed multiply by a coefficient word built from shifted partial sums.
module wl97_shadd #(
    parameter int VW = 20,
    parameter int CW = 17
) (
    input  logic signed [VW-1:0]    v,
    input  logic signed [CW-1:0]    c,
    output logic signed [VW+CW-1:0] p
);
    localparam int PW = VW + CW;

    logic signed [PW-1:0] ext;
    assign ext = PW'(v);

    always_comb begin
        p = '0;
        for (int i = 0; i < CW - 1; i++) begin
            if (c[i]) p = p + (ext <<< i);
        end
        if (c[CW-1]) p = p - (ext <<< (CW - 1));
    end
endmodule

// File: rtl/wl97_nbr.sv
// Neighbour positions of idx with whole-sample symmetric mirroring at both ends.
module wl97_nbr #(
    parameter int CNTW = 6,
    parameter int AW   = 5
) (
    input  logic [CNTW-1:0] idx,
    input  logic [CNTW-1:0] len,
    output logic [AW-1:0]   lo,
    output logic [AW-1:0]   hi
);
    logic [AW-1:0] ia;
    assign ia = idx[AW-1:0];

    always_comb begin
        lo = (ia == '0) ? AW'(1) : ia - AW'(1);
        hi = ((idx + CNTW'(1)) >= len) ? ia - AW'(1) : ia + AW'(1);
    end
endmodule

// File: rtl/wl97_fold_dwt.sv
module wl97_fold_dwt #(
    parameter int DW   = 10,
    parameter int NMAX = 32,
    parameter int FB   = 6,
    parameter int CF   = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic signed [DW-1:0] in_data,
    input  logic                 in_last,
    output logic                 out_valid,
    output logic                 out_high,
    output logic signed [DW+3:0] out_data
);
    import wl97_pkg::*;

    localparam int IW   = DW + FB + 5;
    localparam int OW   = DW + 4;
    localparam int CW   = CF + 3;
    localparam int AW   = $clog2(NMAX);
    localparam int CNTW = $clog2(NMAX + 2);
    localparam int SW   = IW + 1;
    localparam int LPW  = SW + CW;
    localparam int SPW  = IW + CW;

    localparam logic signed [CW-1:0] C_A  = CW'(qcoef(LIFT_A, CF));
    localparam logic signed [CW-1:0] C_B  = CW'(qcoef(LIFT_B, CF));
    localparam logic signed [CW-1:0] C_G  = CW'(qcoef(LIFT_G, CF));
    localparam logic signed [CW-1:0] C_D  = CW'(qcoef(LIFT_D, CF));
    localparam logic signed [CW-1:0] C_K  = CW'(qcoef(NORM_K, CF));
    localparam logic signed [CW-1:0] C_KI = CW'(qcoef(1.0 / NORM_K, CF));
    localparam logic signed [LPW-1:0] LHALF = LPW'(1) <<< (CF - 1);
    localparam logic signed [SPW-1:0] SHALF = SPW'(1) <<< (CF + FB - 1);

    typedef struct packed {
        phase_e                st;
        logic [1:0]            pass;
        logic [CNTW-1:0]       cnt;
        logic [CNTW-1:0]       len;
        logic                  ov;
        logic                  oh;
        logic signed [OW-1:0]  od;
    } ctl_t;

    ctl_t d, q;
    logic signed [IW-1:0] mem_d [NMAX];
    logic signed [IW-1:0] mem_q [NMAX];

    // shared lifting path: neighbour sum, constant product, rounding, accumulate
    logic [AW-1:0]         nb_lo, nb_hi;
    logic signed [CW-1:0]  coef;
    logic signed [SW-1:0]  nsum;
    logic signed [LPW-1:0] lprod, lrnd;
    logic signed [IW-1:0]  lnew;

    wl97_nbr #(.CNTW(CNTW), .AW(AW)) u_nbr (
        .idx(q.cnt), .len(q.len), .lo(nb_lo), .hi(nb_hi)
    );

    always_comb begin
        case (q.pass)
            2'd0:    coef = C_A;
            2'd1:    coef = C_B;
            2'd2:    coef = C_G;
            default: coef = C_D;
        endcase
    end

    assign nsum = SW'(mem_q[nb_lo]) + SW'(mem_q[nb_hi]);

    wl97_shadd #(.VW(SW), .CW(CW)) u_lift_mul (.v(nsum), .c(coef), .p(lprod));

    assign lrnd = (lprod + LHALF) >>> CF;
    assign lnew = mem_q[q.cnt[AW-1:0]] + IW'(lrnd);

    // output scaling path
    logic signed [CW-1:0]  ksel;
    logic signed [SPW-1:0] sprod, srnd;

    assign ksel = q.cnt[0] ? C_KI : C_K;

    wl97_shadd #(.VW(IW), .CW(CW)) u_scale_mul (
        .v(mem_q[q.cnt[AW-1:0]]), .c(ksel), .p(sprod)
    );

    assign srnd = (sprod + SHALF) >>> (CF + FB);

    always_comb begin
        d     = q;
        mem_d = mem_q;
        d.ov  = 1'b0;
        case (q.st)
            PH_LOAD: begin
                if (in_valid) begin
                    mem_d[q.cnt[AW-1:0]] = IW'(in_data) <<< FB;
                    if (in_last || (q.cnt == CNTW'(NMAX - 1))) begin
                        d.st   = PH_LIFT;
                        d.len  = q.cnt + CNTW'(1);
                        d.pass = 2'd0;
                        d.cnt  = CNTW'(1);
                    end else begin
                        d.cnt = q.cnt + CNTW'(1);
                    end
                end
            end
            PH_LIFT: begin
                if (q.cnt < q.len) mem_d[q.cnt[AW-1:0]] = lnew;
                if ((q.cnt + CNTW'(2)) >= q.len) begin
                    if (q.pass == 2'd3) begin
                        d.st  = PH_EMIT;
                        d.cnt = '0;
                    end else begin
                        d.pass = q.pass + 2'd1;
                        d.cnt  = q.pass[0] ? CNTW'(1) : CNTW'(0);
                    end
                end else begin
                    d.cnt = q.cnt + CNTW'(2);
                end
            end
            default: begin
                d.ov = 1'b1;
                d.oh = q.cnt[0];
                d.od = OW'(srnd);
                if (q.cnt == q.len - CNTW'(1)) begin
                    d.st  = PH_LOAD;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + CNTW'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
            for (int i = 0; i < NMAX; i++) mem_q[i] <= '0;
        end else begin
            q     <= d;
            mem_q <= mem_d;
        end
    end

    assign in_ready  = (q.st == PH_LOAD);
    assign out_valid = q.ov;
    assign out_high  = q.oh;
    assign out_data  = q.od;

    // R1
    blk_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (in_last || q.cnt == CNTW'(NMAX - 1))) |=> !in_ready);
    // R2
    ready_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !$past(in_ready)) |-> out_valid);
    // R3
    tag_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> (out_high != $past(out_high)));
    // R3
    first_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> !out_high);
    // R4
    pass_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == PH_LIFT && $past(q.st == PH_LIFT)) |->
        (q.pass == $past(q.pass) || q.pass == $past(q.pass) + 2'd1));
endmodule

// File: tb/wl97_fold_dwt_test.sv
module wl97_fold_dwt_test;
    localparam int DW   = 10;
    localparam int NMAX = 32;
    localparam real KN  = 1.149604398;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_last = 1'b0;
    logic signed [DW-1:0] in_data = '0;
    logic in_ready, out_valid, out_high;
    logic signed [DW+3:0] out_data;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wl97_fold_dwt #(.DW(DW), .NMAX(NMAX)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
        .out_high(out_high), .out_data(out_data)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(bit ok, string req, string what, real act, real exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0f expected %0f", req, what, act, exp);
        end
    endtask

    function automatic int mir(int j, int n);
        if (j < 0) return -j;
        if (j > n - 1) return 2 * (n - 1) - j;
        return j;
    endfunction

    // mode: 0 impulse mid, 1 ramp, 2 random, 3 constant, 4 impulse at first, 5 impulse at last
    task automatic run_block(int n, int mode, bit gaps, bit use_last);
        int smp[$];
        real x[];
        real c[4];
        real e;
        real df;
        int k;
        int waitc;
        bit seen;
        c[0] = -1.586134342; c[1] = -0.052980118;
        c[2] = 0.8829110762; c[3] = 0.4435068522;
        for (int i = 0; i < n; i++) begin
            case (mode)
                0: smp.push_back(i == n / 2 ? 256 : 0);
                1: smp.push_back(i * 30 - 480);
                2: smp.push_back($urandom_range(1022) - 511);
                3: smp.push_back(-400);
                4: smp.push_back(i == 0 ? 511 : 0);
                default: smp.push_back(i == n - 1 ? -512 : 0);
            endcase
        end
        x = new[n];
        for (int i = 0; i < n; i++) x[i] = smp[i];
        // R4 R5: reference lifting with mirrored ends
        for (int p = 0; p < 4; p++) begin
            for (int i = (p % 2 == 0) ? 1 : 0; i < n; i += 2)
                x[i] = x[i] + c[p] * (x[mir(i - 1, n)] + x[mir(i + 1, n)]);
        end
        // R1 R9: feed the block, optionally with idle gaps
        for (int i = 0; i < n; i++) begin
            if (gaps && $urandom_range(2) == 0) begin
                in_valid = 1'b0;
                in_data  = '1;
                in_last  = 1'b1;
                @(negedge clk);
            end
            chk(in_ready == 1'b1, "R1", "ready while loading", in_ready, 1);
            in_valid = 1'b1;
            in_data  = DW'(smp[i]);
            in_last  = use_last && (i == n - 1);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        chk(in_ready == 1'b0, "R1", "ready after block close", in_ready, 0);
        k = 0;
        waitc = 0;
        seen = 1'b0;
        while (k < n && waitc < 6 * NMAX + 40) begin
            if (out_valid) begin
                seen = 1'b1;
                // R3 R8 tag by position
                chk(out_high == (k % 2), "R3", "tag", out_high, k % 2);
                e = (k % 2 == 0) ? x[k] * KN : x[k] / KN;
                df = $itor(out_data) - e;
                if (df < 0.0) df = -df;
                // R6 value within one of exact transform
                chk(df <= 1.0, "R6", "coefficient", $itor(out_data), e);
                // R2 ready returns exactly with the last coefficient
                chk(in_ready == (k == n - 1), "R2", "ready during emit", in_ready, (k == n - 1));
                k++;
            end else begin
                if (seen) chk(1'b0, "R3", "gap in output", 0, 1);
                chk(in_ready == 1'b0, "R2", "ready while busy", in_ready, 0);
            end
            waitc++;
            @(negedge clk);
        end
        chk(k == n, "R3", "output count", k, n);
        chk(out_valid == 1'b0, "R3", "valid after block", out_valid, 0);
        if (n % 2 == 1) chk(k == n, "R8", "odd length lone low", k, n);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R7 reset state
        chk(in_ready == 1'b1, "R7", "in_ready at reset", in_ready, 1);
        chk(out_valid == 1'b0, "R7", "out_valid at reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_block(16, 0, 1'b0, 1'b1);   // impulse
        run_block(16, 1, 1'b0, 1'b1);   // ramp
        run_block(16, 2, 1'b1, 1'b1);   // random with gaps (R9)
        run_block(9, 2, 1'b0, 1'b1);    // odd length (R8)
        run_block(7, 4, 1'b0, 1'b1);    // first-position mirror (R5)
        run_block(8, 5, 1'b0, 1'b1);    // last-position mirror, even (R5)
        run_block(9, 5, 1'b1, 1'b1);    // last-position mirror, odd (R5)
        run_block(2, 2, 1'b0, 1'b1);    // shortest block
        run_block(NMAX, 2, 1'b0, 1'b0); // forced close at depth (R1)
        run_block(31, 2, 1'b1, 1'b1);
        run_block(12, 3, 1'b0, 1'b1);   // constant
        for (int r = 0; r < 6; r++) run_block(3 + r * 5, 2, r[0], 1'b1);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule